// File: doc/BRIEF.md
# Page-Level Single-Error-Correcting Parity Engine

This engine sits beside a NAND flash data path and watches every data beat that crosses it. Across the whole data area of one page, it folds each word into a Hamming-style parity pair. The bus may be 8 bits or 16 bits wide. The first parity word XORs together the position `{word index, bit index}` of every set data bit. The second parity word XORs together the complement of each such position.

When a page is written, software reads both 16-bit parity words once the data has passed and stores them in the spare area. When a page is read, the four stored parity bytes must follow the data directly on the same bus. The engine compares them with its own result and classifies the page. The result is one of four outcomes:

- no error;
- one flipped data bit, whose word and bit position are reported;
- one flipped bit inside the stored code;
- an uncorrectable pattern, where an all-ones position marks an erased page.

A small register port sets the page geometry, bus width and direction, restarts the computation, and returns status and parity.

Top module: `hecc_engine`

## Requirements
- R1: After reset, every register reads zero: mode (512 data bytes, 8-bit bus, generate direction), status, parity and inverse parity. `s_ready` is 1.
- R2: On an 8-bit bus, only `s_data[7:0]` counts. For each set bit b of data word w, the parity (register 3) accumulates `{w[11:0], b[3:0]}` by XOR, and the inverse parity (register 4) accumulates its complement.
- R3: With the mode register bit 2 set (16-bit bus), all 16 data bits count with bit index 0..15, and w counts 16-bit words.
- R4: Mode bits [1:0] = n select a data area of 512<<n bytes. Beats after the data area never change the parity registers.
- R5: Writing 1 to bit 0 of register 1 clears the parity, word counter and status. A data beat in that same cycle is taken as word 0 of the new page. A write to the mode register (register 0) restarts in the same way.
- R6: With mode bit 3 set (check direction), the engine takes the beats after the data as stored parity: 4 bytes on 8 bits (parity low, parity high, inverse low, inverse high) or 2 words on 16 bits (parity, inverse). If they match, status (register 2) reads 0 and register 3 reads the computed parity.
- R7: For one flipped data bit at (w,b), status reads 1 (bit 0 = recoverable error), and register 3 reads `{w, b}`.
- R8: For one flipped bit in the stored code, status reads 3 (bit 1 = error in code), and register 3 reads the parity syndrome (stored XOR computed).
- R9: Any other nonzero mismatch sets status to 5 (bit 2 = multiple error), and register 3 reads the parity syndrome. An erased page (all 0xFF data and code) reads location 0xFFFF.
- R10: Beats after the stored-code field are ignored. Status and location stay unchanged until the next clear or mode write.
- R11: The engine never applies back-pressure: `s_ready` stays 1, and every `s_valid` beat is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | A data beat is on the bus |
| s_ready | output | 1 | Always 1; the engine only observes the bus |
| s_data | input | 16 | Bus word; low byte only on an 8-bit bus |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 mode, 1 control, 2 status, 3 parity, 4 inverse parity |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register, combinational |

## Verification
A software restart and a data beat can land on the same clock edge. This happens when address or command traffic is still on the bus while the clear is issued. The bench drives both in one cycle on purpose: a control write of 1 together with `s_valid` carrying the page's first word, after a few junk beats. It then finishes the page, so the resulting parity equals a model in which that beat is word 0 and the junk beats are absent. A clear with no beat must leave the parity at zero.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  typedef enum logic [2:0] {
    RA_MODE = 3'd0,
    RA_CTRL = 3'd1,
    RA_STAT = 3'd2,
    RA_PAR  = 3'd3,
    RA_NPAR = 3'd4
  } reg_addr_e;

  // mode register layout: [3] check direction, [2] 16-bit bus, [1:0] page size code
  typedef struct packed {
    logic       chk;
    logic       bus16;
    logic [1:0] psz;
  } mode_t;

  // status register layout: [2] multiple, [1] error in code, [0] recoverable
  typedef struct packed {
    logic mul;
    logic eccerr;
    logic rec;
  } status_t;

  localparam int MODE_W = $bits(mode_t);
  localparam int STAT_W = $bits(status_t);

endpackage

// File: rtl/hecc_seq.sv
module hecc_seq #(
  parameter int WIDX_W = 12,
  parameter int CNT_W  = 14,
  parameter int NECC8  = 4,
  parameter int NECC16 = 2,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              beat,
  input  logic [1:0]        psz,
  input  logic              bus16,
  output logic [WIDX_W-1:0] widx,
  output logic              in_data,
  output logic              in_ecc,
  output logic [SLOT_W-1:0] slot,
  output logic              last_ecc
);
  localparam int BASE = 2 ** (WIDX_W - 3);

  logic [CNT_W-1:0] cnt, eff, nwords, nlim;

  always_comb begin
    nwords   = (CNT_W'(BASE) << psz) >> bus16;
    nlim     = nwords + (bus16 ? CNT_W'(NECC16) : CNT_W'(NECC8));
    eff      = restart ? '0 : cnt;
    in_data  = eff < nwords;
    in_ecc   = !in_data && (eff < nlim);
    widx     = eff[WIDX_W-1:0];
    slot     = SLOT_W'(eff - nwords);
    last_ecc = in_ecc && (eff == nlim - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (restart)                    cnt <= beat ? CNT_W'(1) : '0;
    else if (beat && (in_data || in_ecc)) cnt <= cnt + CNT_W'(1);
  end

  // R10
  tail_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !restart && !in_data && !in_ecc) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/hecc_accum.sv
module hecc_accum #(
  parameter int DAT_W  = 16,
  parameter int WIDX_W = 12,
  parameter int BIDX_W = 4,
  parameter int PAR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              take,
  input  logic              bus16,
  input  logic [WIDX_W-1:0] widx,
  input  logic [DAT_W-1:0]  data,
  output logic [PAR_W-1:0]  p,
  output logic [PAR_W-1:0]  np
);
  logic [PAR_W-1:0] pc, npc;
  logic             odd;

  // XOR of the positions of all counted set bits; complement half differs by overall parity
  always_comb begin
    pc  = '0;
    odd = 1'b0;
    for (int b = 0; b < DAT_W; b++) begin
      if (data[b] && (bus16 || b < DAT_W / 2)) begin
        pc  = pc ^ {widx, BIDX_W'(b)};
        odd = ~odd;
      end
    end
    npc = pc ^ {PAR_W{odd}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p  <= '0;
      np <= '0;
    end else begin
      p  <= (restart ? '0 : p)  ^ (take ? pc  : '0);
      np <= (restart ? '0 : np) ^ (take ? npc : '0);
    end
  end

  // R5
  clear_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !take) |=> (p == '0 && np == '0));

endmodule

// File: rtl/hecc_judge.sv
module hecc_judge #(
  parameter int PAR_W = 16
) (
  input  logic [PAR_W-1:0] p_calc,
  input  logic [PAR_W-1:0] np_calc,
  input  logic [PAR_W-1:0] p_st,
  input  logic [PAR_W-1:0] np_st,
  output logic             rec,
  output logic             eccerr,
  output logic             mul,
  output logic [PAR_W-1:0] loc
);
  logic [PAR_W-1:0] syn, nsyn;

  always_comb begin
    syn    = p_st ^ p_calc;
    nsyn   = np_st ^ np_calc;
    loc    = syn;
    rec    = 1'b0;
    eccerr = 1'b0;
    mul    = 1'b0;
    if (syn != '0 || nsyn != '0) begin
      rec = 1'b1;
      if ((syn ^ nsyn) == {PAR_W{1'b1}}) begin
        // one data bit: halves are exact complements
      end else if ($countones({syn, nsyn}) == 1) begin
        eccerr = 1'b1;
      end else begin
        mul = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hecc_engine.sv
module hecc_engine
  import hecc_pkg::*;
#(
  parameter int DAT_W  = 16,
  parameter int WIDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [DAT_W-1:0] s_data,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [WIDX_W+$clog2(DAT_W)-1:0] reg_wdata,
  output logic [WIDX_W+$clog2(DAT_W)-1:0] reg_rdata
);
  localparam int BIDX_W = $clog2(DAT_W);
  localparam int PAR_W  = WIDX_W + BIDX_W;
  localparam int BYTE_W = DAT_W / 2;
  localparam int ST_W   = 2 * PAR_W;
  localparam int NECC8  = ST_W / BYTE_W;
  localparam int NECC16 = ST_W / DAT_W;
  localparam int SLOT_W = $clog2(NECC8);
  localparam int CNT_W  = WIDX_W + 2;

  mode_t             mode_r;
  status_t           status_r;
  logic [PAR_W-1:0]  loc_r;
  logic [ST_W-1:0]   stored, st_nx;
  logic              beat, restart, fin;
  logic [WIDX_W-1:0] widx;
  logic              in_data, in_ecc, last_ecc;
  logic [SLOT_W-1:0] slot;
  logic [PAR_W-1:0]  p_acc, np_acc, j_loc;
  logic              j_rec, j_eccerr, j_mul;
  reg_addr_e         sel;
  logic              wdata_unused;

  assign s_ready      = 1'b1;
  assign beat         = s_valid && s_ready;
  assign sel          = reg_addr_e'(reg_sel);
  assign restart      = reg_we && ((sel == RA_MODE) || (sel == RA_CTRL && reg_wdata[0]));
  assign wdata_unused = ^reg_wdata[PAR_W-1:MODE_W];

  hecc_seq #(
    .WIDX_W(WIDX_W), .CNT_W(CNT_W), .NECC8(NECC8), .NECC16(NECC16), .SLOT_W(SLOT_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .beat(beat),
    .psz(mode_r.psz), .bus16(mode_r.bus16), .widx(widx),
    .in_data(in_data), .in_ecc(in_ecc), .slot(slot), .last_ecc(last_ecc)
  );

  hecc_accum #(
    .DAT_W(DAT_W), .WIDX_W(WIDX_W), .BIDX_W(BIDX_W), .PAR_W(PAR_W)
  ) acc_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .take(beat && in_data),
    .bus16(mode_r.bus16), .widx(widx), .data(s_data), .p(p_acc), .np(np_acc)
  );

  // merge the current code beat into the stored parity image
  always_comb begin
    st_nx = stored;
    if (mode_r.bus16) st_nx[int'(slot[0]) * DAT_W +: DAT_W] = s_data;
    else              st_nx[int'(slot) * BYTE_W +: BYTE_W]  = s_data[BYTE_W-1:0];
  end

  hecc_judge #(.PAR_W(PAR_W)) judge_i (
    .p_calc(p_acc), .np_calc(np_acc),
    .p_st(st_nx[PAR_W-1:0]), .np_st(st_nx[ST_W-1:PAR_W]),
    .rec(j_rec), .eccerr(j_eccerr), .mul(j_mul), .loc(j_loc)
  );

  assign fin = beat && last_ecc && mode_r.chk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r   <= '0;
      status_r <= '0;
      loc_r    <= '0;
      stored   <= '0;
    end else begin
      if (reg_we && sel == RA_MODE) mode_r <= mode_t'(reg_wdata[MODE_W-1:0]);
      if (restart) begin
        status_r <= '0;
        loc_r    <= '0;
        stored   <= '0;
      end else begin
        if (beat && in_ecc) stored <= st_nx;
        if (fin) begin
          status_r <= '{mul: j_mul, eccerr: j_eccerr, rec: j_rec};
          loc_r    <= j_loc;
        end
      end
    end
  end

  always_comb begin
    unique case (sel)
      RA_MODE: reg_rdata = PAR_W'(mode_r);
      RA_STAT: reg_rdata = PAR_W'(status_r);
      RA_PAR:  reg_rdata = status_r.rec ? loc_r : p_acc;
      RA_NPAR: reg_rdata = np_acc;
      default: reg_rdata = '0;
    endcase
  end

  // R8
  flag_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_r.mul || status_r.eccerr) |-> (status_r.rec && !(status_r.mul && status_r.eccerr)));

  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !fin) |=> ($stable(status_r) && $stable(loc_r)));

  // R6
  gen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_r.chk |-> (status_r == '0));

endmodule

// File: tb/hecc_engine_tb_top.sv
module hecc_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [15:0] pg [0:4095];
  logic [15:0] tx [0:4095];

  always #5 clk = ~clk;

  hecc_engine dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [15:0] val);
    @(negedge clk);
    reg_sel = sel;
    #1 val = reg_rdata;
  endtask

  function automatic logic [15:0] mode_word(bit chk_dir, bit b16, int psz);
    return {12'd0, chk_dir, b16, 2'(psz)};
  endfunction

  function automatic int nwords(int psz, bit b16);
    return (512 << psz) >> b16;
  endfunction

  function automatic logic [31:0] ecc_of(int nw, bit b16);
    logic [15:0] p = '0, np = '0, a;
    for (int w = 0; w < nw; w++)
      for (int b = 0; b < (b16 ? 16 : 8); b++)
        if (pg[w][b]) begin
          a  = {w[11:0], 4'(b)};
          p  = p ^ a;
          np = np ^ ~a;
        end
    return {np, p};
  endfunction

  task automatic fill_random(int nw);
    for (int i = 0; i < nw; i++) begin
      pg[i] = 16'($urandom);
      tx[i] = pg[i];
    end
  endtask

  task automatic send_range(int from, int to);
    for (int i = from; i < to; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = tx[i];
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic send_ecc(input logic [31:0] e, input bit b16);
    for (int i = 0; i < (b16 ? 2 : 4); i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      if (b16) s_data = e[i*16 +: 16];
      else     s_data = {8'($urandom), e[i*8 +: 8]};
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic send_junk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = 16'($urandom);
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic check_page(int psz, bit b16, input logic [31:0] e);
    wr(3'd0, mode_word(1'b1, b16, psz));
    send_range(0, nwords(psz, b16));
    send_ecc(e, b16);
  endtask

  initial begin
    logic [15:0] v, v2;
    logic [31:0] e, m;
    int nw, w1, w2, b1, b2, psz;
    bit b16;
    v = 16'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R11 no back-pressure
    rd(3'd0, v); chk("R1 mode", v, 16'h0000);
    rd(3'd2, v); chk("R1 status", v, 16'h0000);
    rd(3'd3, v); chk("R1 parity", v, 16'h0000);
    rd(3'd4, v); chk("R1 inverse", v, 16'h0000);
    chk("R11 ready", {15'd0, s_ready}, 16'h0001);

    // R2 generate, 8-bit, 512 bytes; upper byte of bus is junk
    wr(3'd0, mode_word(1'b0, 1'b0, 0));
    rd(3'd0, v); chk("R1 mode readback", v, 16'h0000);
    fill_random(512); send_range(0, 512); e = ecc_of(512, 1'b0);
    rd(3'd3, v); chk("R2 parity 8b", v, e[15:0]);
    rd(3'd4, v); chk("R2 inverse 8b", v, e[31:16]);
    // R4 beats beyond the data area change nothing
    send_junk(9);
    rd(3'd3, v); chk("R4 parity after tail", v, e[15:0]);
    rd(3'd4, v); chk("R4 inverse after tail", v, e[31:16]);

    // R3 16-bit bus, 1024 bytes
    wr(3'd0, mode_word(1'b0, 1'b1, 1));
    fill_random(512); send_range(0, 512); e = ecc_of(512, 1'b1);
    rd(3'd3, v); chk("R3 parity 16b", v, e[15:0]);
    rd(3'd4, v); chk("R3 inverse 16b", v, e[31:16]);

    // R4 page size 2048 bytes on 8 bits
    wr(3'd0, mode_word(1'b0, 1'b0, 2));
    fill_random(2048); send_range(0, 2048); e = ecc_of(2048, 1'b0);
    rd(3'd3, v); chk("R4 parity 2048", v, e[15:0]);
    send_junk(5);
    rd(3'd4, v); chk("R4 inverse 2048", v, e[31:16]);

    // R5 clear with no beat
    wr(3'd1, 16'h0001);
    rd(3'd3, v); chk("R5 clear parity", v, 16'h0000);
    rd(3'd4, v); chk("R5 clear inverse", v, 16'h0000);

    // R5 clear coinciding with the first data beat
    wr(3'd0, mode_word(1'b0, 1'b0, 0));
    fill_random(512); send_junk(3);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd1; reg_wdata = 16'h0001;
    s_valid = 1'b1; s_data = tx[0];
    @(negedge clk);
    reg_we = 1'b0; s_valid = 1'b0;
    send_range(1, 512); e = ecc_of(512, 1'b0);
    rd(3'd3, v); chk("R5 same-cycle parity", v, e[15:0]);
    rd(3'd4, v); chk("R5 same-cycle inverse", v, e[31:16]);

    // R6 clean check on both widths
    for (int it = 0; it < 2; it++) begin
      b16 = it[0]; nw = nwords(0, b16);
      fill_random(nw); e = ecc_of(nw, b16);
      check_page(0, b16, e);
      rd(3'd2, v); chk("R6 clean status", v, 16'h0000);
      rd(3'd3, v); chk("R6 clean parity", v, e[15:0]);
    end

    // R7 single data-bit error
    for (int it = 0; it < 6; it++) begin
      b16 = it[0]; psz = it % 3; nw = nwords(psz, b16);
      fill_random(nw); e = ecc_of(nw, b16);
      w1 = $urandom_range(nw - 1); b1 = $urandom_range(b16 ? 15 : 7);
      tx[w1][b1] = ~tx[w1][b1];
      check_page(psz, b16, e);
      rd(3'd2, v); chk("R7 status", v, 16'h0001);
      rd(3'd3, v); chk("R7 location", v, {w1[11:0], 4'(b1)});
      if (it == 0) begin
        // R10 tail beats after the code field leave the result intact
        send_junk(6);
        rd(3'd2, v2); chk("R10 status held", v2, 16'h0001);
        rd(3'd3, v2); chk("R10 location held", v2, {w1[11:0], 4'(b1)});
      end
    end

    // R8 one flipped bit inside the stored code
    for (int it = 0; it < 4; it++) begin
      b16 = it[1]; nw = nwords(0, b16);
      fill_random(nw); e = ecc_of(nw, b16);
      m = 32'd1 << $urandom_range(31);
      check_page(0, b16, e ^ m);
      rd(3'd2, v); chk("R8 status", v, 16'h0003);
      rd(3'd3, v); chk("R8 syndrome", v, m[15:0]);
    end

    // R9 two data-bit errors
    for (int it = 0; it < 3; it++) begin
      b16 = it[0]; nw = nwords(1, b16);
      fill_random(nw); e = ecc_of(nw, b16);
      w1 = $urandom_range(nw - 1); b1 = $urandom_range(b16 ? 15 : 7);
      w2 = (w1 + 1 + $urandom_range(nw - 2)) % nw; b2 = $urandom_range(b16 ? 15 : 7);
      tx[w1][b1] = ~tx[w1][b1];
      tx[w2][b2] = ~tx[w2][b2];
      check_page(1, b16, e);
      rd(3'd2, v); chk("R9 status", v, 16'h0005);
      rd(3'd3, v); chk("R9 syndrome", v, {w1[11:0], 4'(b1)} ^ {w2[11:0], 4'(b2)});
    end

    // R9 erased page
    for (int i = 0; i < 512; i++) begin pg[i] = 16'hFFFF; tx[i] = 16'hFFFF; end
    check_page(0, 1'b0, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R9 erased status", v, 16'h0005);
    rd(3'd3, v); chk("R9 erased location", v, 16'hFFFF);

    // R10 result stays until a clear, then clears
    send_junk(4);
    rd(3'd2, v); chk("R10 erased held", v, 16'h0005);
    wr(3'd1, 16'h0001);
    rd(3'd2, v); chk("R10 cleared status", v, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL R11 watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule